// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit fetches the source operand for a load-type instruction on a byte-addressed machine that uses 32-bit instruction words. A request carries a three-bit mode code, a register value, a signed displacement or constant, and the address of the current instruction. From these the unit works out an effective address. It then makes zero, one or two reads through a simple request/ready data-memory port. It returns the operand as a single-cycle result strobe with data.

There are eight modes. Two need no memory access: the constant is returned as it is, or the register is returned as it is. Four modes make one read: the address comes from the constant, from the register, from register plus displacement, or from instruction address plus displacement. The memory-indirect mode makes two reads in a row: the first read fetches a pointer and the second read fetches the operand. An effective-address variant returns register plus displacement and does not read memory. The unit takes a new request only while it is idle. The register file, the decoder and the write-back path sit outside it.

Top module: `operand_addr_unit`

## Requirements
- R1: Mode 0 (immediate) returns the displacement input unchanged. It issues no memory read, and the result strobe comes in the cycle after acceptance.
- R2: Mode 1 (direct) makes one read at the displacement value and returns the data read.
- R3: Mode 2 (memory-indirect) first reads at the displacement value. It then reads at the data that came back, and returns the data from the second read. This is exactly two reads.
- R4: Mode 3 (register) returns the register input with no read. Mode 4 (register-indirect) makes one read at the register value and returns the data read.
- R5: Mode 5 (based) makes one read at register + displacement. For example, register 300 with displacement -100 reads location 200.
- R6: Mode 6 (effective address) returns register + displacement with no memory read.
- R7: Mode 7 (relative) makes one read at instruction address + displacement. For example, address 100 with displacement 200 reads location 300.
- R8: All address sums are 32-bit two's complement and wrap on overflow. A read result used as a pointer also wraps in this way.
- R9: A request is accepted only while `idle` is high. `idle` goes low in the cycle after acceptance and stays low until the result strobe has been given. A request presented while the unit is busy is dropped: it produces no read and no result.
- R10: After reset, `idle` is high and `res_valid` and `mem_req` are low. `res_valid` is high for exactly one cycle per accepted request.
- R11: While `mem_req` is high and `mem_rdy` is low, `mem_req` stays high and `mem_addr` holds its value. Data is taken in the cycle in which `mem_rdy` is high. The latency from acceptance to the result is 1 + the sum over all reads of (wait cycles + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing mode code, 0 to 7 |
| req_reg | input | 32 | Register operand value |
| req_disp | input | 32 | Signed displacement or constant |
| req_pc | input | 32 | Address of the current instruction |
| idle | output | 1 | Unit can accept a request |
| mem_req | output | 1 | Data-memory read request |
| mem_addr | output | 32 | Read address |
| mem_rdy | input | 1 | Read completes this cycle; data is valid |
| mem_rdata | input | 32 | Read data |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Resolved operand |

## Verification
If the state register moves to the wrong place, the fault reaches the ports within one cycle. An extra or missing read changes both the number of `mem_req`/`mem_rdy` handshakes and the exact cycle of `res_valid`. A pointer latched wrongly in the indirect mode gives a wrong final data value, because the bench memory maps each address to a distinct word. A state that fails to return to idle shows up as a missing `idle` or as a second strobe in the cycles after the result.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_DIR   = 3'd1,
    AM_MIND  = 3'd2,
    AM_REG   = 3'd3,
    AM_RIND  = 3'd4,
    AM_BASED = 3'd5,
    AM_LEA   = 3'd6,
    AM_REL   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;

  // Wrapping sum used for every address computation
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  // Address for read modes, or final value for modes with no read
  function automatic logic [DW-1:0] first_value(input amode_e m, input logic [DW-1:0] r,
                                                input logic [DW-1:0] d, input logic [DW-1:0] pc);
    case (m)
      AM_IMM, AM_DIR, AM_MIND: return d;
      AM_REG, AM_RIND:         return r;
      AM_BASED, AM_LEA:        return wrap_add(r, d);
      default:                 return wrap_add(pc, d);
    endcase
  endfunction

  function automatic logic mode_reads(input amode_e m);
    return !(m == AM_IMM || m == AM_REG || m == AM_LEA);
  endfunction
endpackage

// File: rtl/oau_addr_gen.sv
module oau_addr_gen
  import oau_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] pc,
  output logic [W-1:0] value,
  output logic         needs_read,
  output logic         two_reads
);
  amode_e m;

  always_comb begin
    m          = amode_e'(mode);
    value      = first_value(m, reg_val, disp, pc);
    needs_read = mode_reads(m);
    two_reads  = (m == AM_MIND);
  end
endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         needs_read,
  input  logic         two_reads,
  input  logic [W-1:0] value,
  input  logic         mem_rdy,
  input  logic [W-1:0] mem_rdata,
  output logic         idle,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  seq_state_e  state;
  logic [W-1:0] addr_q, data_q;
  logic         two_q;
  logic         rd_done;   // a read handshake completes this cycle
  logic         ptr_step;  // first read of an indirect access finishes

  assign idle      = (state == ST_IDLE);
  assign mem_req   = (state == ST_RD1) || (state == ST_RD2);
  assign mem_addr  = addr_q;
  assign res_valid = (state == ST_RESP);
  assign res_data  = data_q;
  assign rd_done   = mem_req && mem_rdy;
  assign ptr_step  = (state == ST_RD1) && mem_rdy && two_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      two_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          two_q <= two_reads;
          if (needs_read) begin
            addr_q <= value;
            state  <= ST_RD1;
          end else begin
            data_q <= value;
            state  <= ST_RESP;
          end
        end
        ST_RD1: if (mem_rdy) begin
          if (two_q) begin
            addr_q <= mem_rdata;
            state  <= ST_RD2;
          end else begin
            data_q <= mem_rdata;
            state  <= ST_RESP;
          end
        end
        ST_RD2: if (mem_rdy) begin
          data_q <= mem_rdata;
          state  <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: address and request held while memory stalls
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));
  // R10: result strobe is a single-cycle pulse
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R9: no read traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req);
  // R9: acceptance makes the unit busy
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> !idle);
  // R1: modes without reads answer in the next cycle
  p_direct_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && !needs_read) |=> (res_valid && !mem_req));
  // R3: indirect pointer fetch is followed by a second read to the fetched pointer
  p_second_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (mem_req && mem_addr == $past(mem_rdata)));
  // R11: a completed single read leads straight to the result
  p_read_to_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !ptr_step) |=> res_valid);
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [2:0]   req_mode,
  input  logic [W-1:0] req_reg,
  input  logic [W-1:0] req_disp,
  input  logic [W-1:0] req_pc,
  output logic         idle,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rdy,
  input  logic [W-1:0] mem_rdata,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  logic [W-1:0] gen_value;
  logic         gen_reads, gen_two;
  logic         accept;

  assign accept = req_valid && idle;

  oau_addr_gen #(.W(W)) u_gen (
    .mode       (req_mode),
    .reg_val    (req_reg),
    .disp       (req_disp),
    .pc         (req_pc),
    .value      (gen_value),
    .needs_read (gen_reads),
    .two_reads  (gen_two)
  );

  oau_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .needs_read (gen_reads),
    .two_reads  (gen_two),
    .value      (gen_value),
    .mem_rdy    (mem_rdy),
    .mem_rdata  (mem_rdata),
    .idle       (idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .res_valid  (res_valid),
    .res_data   (res_data)
  );

  // R9: requests arriving while busy leave the state untouched
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !idle && !res_valid) |=> !idle);
endmodule

// File: tb/operand_addr_unit_test.sv
module operand_addr_unit_test;
  localparam int N = 12;
  localparam logic [31:0] OFS = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic [31:0] req_reg = '0, req_disp = '0, req_pc = '0;
  logic idle, mem_req, res_valid, mem_rdy;
  logic [31:0] mem_addr, mem_rdata, res_data;

  int checks = 0, errors = 0;
  int cur_wait = 0, wait_left = 0, nreads = 0;

  always #4 clk = ~clk;

  operand_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_reg(req_reg), .req_disp(req_disp), .req_pc(req_pc), .idle(idle),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data)
  );

  // Bench memory: every word holds its own address plus a fixed offset
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a + OFS;
  endfunction

  assign mem_rdy   = mem_req && (wait_left == 0);
  assign mem_rdata = mem_rdy ? mem_word(mem_addr) : 32'h0;

  always @(posedge clk) begin
    if (!mem_req || mem_rdy) wait_left <= cur_wait;
    else wait_left <= wait_left - 1;
    if (mem_req && mem_rdy) nreads <= nreads + 1;
  end

  // Vector table
  localparam logic [2:0]  V_MODE [N] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
                                         3'd5, 3'd6, 3'd7, 3'd2};
  localparam logic [31:0] V_REG  [N] = '{32'd0, 32'd0, 32'd0, 32'd300, 32'd300, 32'd300,
                                         32'd300, 32'd0, 32'hFFFF_FFF0, 32'h8000_0000, 32'd0, 32'd0};
  localparam logic [31:0] V_DISP [N] = '{32'd200, 32'd200, 32'd200, 32'd7, 32'd0, -32'sd100,
                                         -32'sd100, 32'd200, 32'h20, 32'h8000_0000, -32'sd128,
                                         32'hFFFF_0000};
  localparam logic [31:0] V_PC   [N] = '{32'd100, 32'd100, 32'd100, 32'd100, 32'd100, 32'd100,
                                         32'd100, 32'd100, 32'd0, 32'd0, 32'h40, 32'd0};
  localparam int          V_WAIT [N] = '{0, 1, 2, 0, 0, 1, 0, 2, 0, 1, 3, 1};
  localparam int          V_NRD  [N] = '{0, 1, 2, 0, 1, 1, 0, 1, 1, 0, 1, 2};
  localparam logic [31:0] V_EXP  [N] = '{32'd200, 32'd200 + OFS, 32'd200 + 2*OFS, 32'd300,
                                         32'd300 + OFS, 32'd200 + OFS, 32'd200, 32'd300 + OFS,
                                         32'h10 + OFS, 32'd0, 32'h0000_FFC0, OFS};
  localparam string       V_TAG  [N] = '{"R1", "R2", "R3", "R4", "R4", "R5", "R6", "R7",
                                         "R8", "R8", "R8", "R8"};

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Issue one request and measure result, latency and read count
  task automatic run(input logic [2:0] m, input logic [31:0] r, input logic [31:0] d,
                     input logic [31:0] pc, input int w, input int nrd,
                     input logic [31:0] exp, input string tag);
    int lat, r0;
    cur_wait = w;
    r0 = nreads;
    req_mode = m; req_reg = r; req_disp = d; req_pc = pc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(res_valid && res_data == exp, tag, "result", res_data, exp);
    check(lat == 1 + nrd * (w + 1), tag, "latency", lat, 1 + nrd * (w + 1));
    check(nreads - r0 == nrd, tag, "read count", nreads - r0, nrd);
    @(negedge clk);
    check(!res_valid && idle, "R10", "strobe width / idle", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #100000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (2) @(negedge clk);
    // R10: reset state
    check(idle && !res_valid && !mem_req, "R10", "reset outputs",
          {29'd0, idle, res_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++)
      run(V_MODE[i], V_REG[i], V_DISP[i], V_PC[i], V_WAIT[i], V_NRD[i], V_EXP[i], V_TAG[i]);

    // R11: address held stable during a long stall
    cur_wait = 4;
    req_mode = 3'd1; req_disp = 32'h1234; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: a request while busy (immediate, different value) must be dropped
    req_mode = 3'd0; req_disp = 32'hDEAD; req_valid = 1'b1;
    check(!idle, "R9", "busy after accept", {31'd0, idle}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      check(mem_req && mem_addr == 32'h1234, "R11", "held address", mem_addr, 32'h1234);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(res_valid && res_data == 32'h1234 + OFS, "R9", "result of first request",
          res_data, 32'h1234 + OFS);
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (res_valid || mem_req) seen++;
    end
    check(seen == 0, "R9", "dropped request left no trace", seen, 0);

    // R1: back-to-back immediates after the unit is idle again
    run(3'd0, 32'd0, 32'hFFFF_FFFF, 32'd0, 0, 0, 32'hFFFF_FFFF, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule